// File: doc/BRIEF.md
# I2C Slave Configuration Register Port

This block is a slave on a two-wire serial bus that holds two 6-bit configuration words (A and B) and one shared 2-bit mode field. A downstream output multiplexer uses all three. The bus lines are oversampled by the system clock. The block recognises bus START and STOP conditions and answers one of two 7-bit addresses, picked by a strap pin. Write data bytes carry their own destination selector in the top two bits.

A read returns a fixed stream: word A, then word B, then the live value of a 6-bit input port. Each byte is zero-padded in its top two bits. Written values do not show up at once. They pass through a commit timer that models a slow non-volatile store, and only then reach the register outputs. A one-cycle strobe on every STOP lets the multiplexer downstream pick up a new selection at the end of a transfer.

Top module: `cfg_i2c_port`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Every STOP raises `stop_pulse` for exactly one clock.
- R2: The slave address is 7'b1001110 when `addr_sel` is 1 and 7'b0110111 when it is 0. A matching address byte is acknowledged by pulling SDA low (`sda_oe` = 1) through the ninth SCL clock.
- R3: Any other address, including the general call address 7'b0000000, gets no acknowledge. After such an address the block keeps SDA released and ignores every following byte until the next START.
- R4: In a write data byte, bit 6 picks the target (0 = word A, 1 = word B) and bits 5:0 are the new value. Bits 7:6 are always stored into the single shared `mode` field, whichever word is written.
- R5: A written byte reaches `reg_a`/`reg_b`/`mode` COMMIT_CYCLES+1 clocks after the data byte is accepted, and not earlier. A new write accepted while a commit is pending replaces it and restarts the timer.
- R6: A read sends MSB first {2'b00, A}, then {2'b00, B}, then {2'b00, in_port}. Any further bytes repeat the input port value sampled when each byte starts.
- R7: A master NACK after a read byte ends transmission and SDA is released. A read ended after the first byte transfers only word A.
- R8: Reads change neither word nor the mode field.
- R9: A repeated START (no STOP before it) restarts address matching, with the bit counter cleared.
- R10: Synchronous active-high reset clears `reg_a`, `reg_b` and `mode` to zero and releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap choosing which slave address is answered |
| in_port | input | 6 | Live input value returned as the third read byte |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_a | output | 6 | Committed configuration word A |
| reg_b | output | 6 | Committed configuration word B |
| mode | output | 2 | Committed shared mode field |
| stop_pulse | output | 1 | One-clock strobe on each STOP condition |

## Verification
Writes are tried with all four values of the top two bits. This separates how the selector chooses the target word from the shared mode field, which takes the same bits whichever word is written. Every write is read back with a four-byte stream, while the input port changes between reads, so the fixed order and the live third byte can be told apart from stale or reordered data. Address bytes go out with the wrong strap, with the general call address, and behind a repeated START, which tells acknowledge decisions apart from any stray drive of SDA. A second write inside the commit window shows whether the timer is replaced or merely queued.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int REG_W  = 6;
  localparam int MODE_W = 2;
  localparam int BYTE_W = REG_W + MODE_W;

  localparam logic [6:0] SLV_ADDR_HI = 7'b1001110;
  localparam logic [6:0] SLV_ADDR_LO = 7'b0110111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } bus_state_t;

  function automatic logic [BYTE_W-1:0] pad_word(input logic [REG_W-1:0] v);
    return {{MODE_W{1'b0}}, v};
  endfunction
endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_p;
  logic [STAGES:0] sda_p;
  logic scl_now, scl_old, sda_now, sda_old;

  assign scl_now = scl_p[STAGES-1];
  assign scl_old = scl_p[STAGES];
  assign sda_now = sda_p[STAGES-1];
  assign sda_old = sda_p[STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p     <= '1;
      sda_p     <= '1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      sda_s     <= 1'b1;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_p     <= {scl_p[STAGES-1:0], scl_i};
      sda_p     <= {sda_p[STAGES-1:0], sda_i};
      scl_rise  <= scl_now & ~scl_old;
      scl_fall  <= ~scl_now & scl_old;
      sda_s     <= sda_now;
      start_det <= scl_now & scl_old & sda_old & ~sda_now;
      stop_det  <= scl_now & scl_old & ~sda_old & sda_now;
    end
  end

  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !stop_det);  // R1
  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(start_det && stop_det));  // R1
endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
  import cfg_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_sel,
  input  logic [REG_W-1:0]  in_port,
  input  logic [REG_W-1:0]  reg_a,
  input  logic [REG_W-1:0]  reg_b,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_byte
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  bus_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              is_addr;
  logic              rd_mode;
  logic              nack;
  logic [1:0]        idx;
  logic [6:0]        my_addr;
  logic [1:0]        idx_next;
  logic [BYTE_W-1:0] first_tx;
  logic [BYTE_W-1:0] next_tx;

  assign my_addr  = addr_sel ? SLV_ADDR_HI : SLV_ADDR_LO;
  assign idx_next = (idx == 2'd2) ? 2'd2 : idx + 2'd1;

  function automatic logic [BYTE_W-1:0] pick(input logic [1:0] i,
      input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
      input logic [REG_W-1:0] p);
    case (i)
      2'd0:    return pad_word(a);
      2'd1:    return pad_word(b);
      default: return pad_word(p);
    endcase
  endfunction

  assign first_tx = pick(2'd0, reg_a, reg_b, in_port);
  assign next_tx  = pick(idx_next, reg_a, reg_b, in_port);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      is_addr  <= 1'b0;
      rd_mode  <= 1'b0;
      nack     <= 1'b0;
      idx      <= '0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_byte  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_det) begin
        state   <= ST_RX;
        bit_cnt <= '0;
        is_addr <= 1'b1;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
              bit_cnt <= '0;
              if (is_addr) begin
                if (shreg[BYTE_W-1:1] == my_addr) begin
                  state   <= ST_ACK;
                  sda_oe  <= 1'b1;
                  rd_mode <= shreg[0];
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                wr_valid <= 1'b1;
                wr_byte  <= shreg;
                state    <= ST_ACK;
                sda_oe   <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              is_addr <= 1'b0;
              if (is_addr && rd_mode) begin
                state  <= ST_TX;
                idx    <= 2'd0;
                shreg  <= first_tx;
                sda_oe <= ~first_tx[BYTE_W-1];
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == CNT_W'(BYTE_W)) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                state   <= ST_RACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                state <= ST_IDLE;
              end else begin
                idx    <= idx_next;
                shreg  <= next_tx;
                sda_oe <= ~next_tx[BYTE_W-1];
                state  <= ST_TX;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);  // R3
  AST_ACK_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && is_addr) |-> (shreg[BYTE_W-1:1] == my_addr));  // R2
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX || state == ST_RACK) |-> !wr_valid);  // R8
  AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_RX && is_addr && bit_cnt == '0));  // R9
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RACK && scl_fall && nack) |=> !sda_oe);  // R7
endmodule

// File: rtl/cfg_commit.sv
module cfg_commit
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned DELAY = 1_250_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [REG_W-1:0]  reg_a,
  output logic [REG_W-1:0]  reg_b,
  output logic [MODE_W-1:0] mode
);
  logic              apply;
  logic [BYTE_W-1:0] pend;

  generate
    if (DELAY == 0) begin : g_direct
      assign apply = wr_valid;
      assign pend  = wr_byte;
    end else begin : g_timed
      localparam int CW = $clog2(DELAY + 1);
      logic [CW-1:0]     cnt;
      logic              busy;
      logic [BYTE_W-1:0] hold;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt  <= '0;
          busy <= 1'b0;
          hold <= '0;
        end else if (wr_valid) begin
          hold <= wr_byte;
          cnt  <= CW'(DELAY - 1);
          busy <= 1'b1;
        end else if (busy) begin
          if (cnt == '0) busy <= 1'b0;
          else           cnt  <= cnt - 1'b1;
        end
      end

      assign apply = busy && (cnt == '0) && !wr_valid;
      assign pend  = hold;

      AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> ($stable(reg_a) && $stable(reg_b) && $stable(mode)));  // R5
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a <= '0;
      reg_b <= '0;
      mode  <= '0;
    end else if (apply) begin
      mode <= pend[BYTE_W-1 -: MODE_W];
      if (pend[REG_W]) reg_b <= pend[REG_W-1:0];
      else             reg_a <= pend[REG_W-1:0];
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (reg_a == '0 && reg_b == '0 && mode == '0));  // R10
endmodule

// File: rtl/cfg_i2c_port.sv
module cfg_i2c_port
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned COMMIT_CYCLES = 1_250_000,
  parameter int          SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_sel,
  input  logic [REG_W-1:0]  in_port,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [REG_W-1:0]  reg_a,
  output logic [REG_W-1:0]  reg_b,
  output logic [MODE_W-1:0] mode,
  output logic              stop_pulse
);
  logic              scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic              wr_valid;
  logic [BYTE_W-1:0] wr_byte;

  cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfg_i2c_engine u_engine (
    .clk(clk), .rst(rst), .addr_sel(addr_sel), .in_port(in_port),
    .reg_a(reg_a), .reg_b(reg_b),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_byte(wr_byte)
  );

  cfg_commit #(.DELAY(COMMIT_CYCLES)) u_commit (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .reg_a(reg_a), .reg_b(reg_b), .mode(mode)
  );

  assign stop_pulse = stop_det;
endmodule

// File: tb/cfg_i2c_port_test.sv
module cfg_i2c_port_test;
  localparam int COMMIT = 2000;
  localparam int H      = 20;
  localparam logic [6:0] ADR_HI = 7'h4E;
  localparam logic [6:0] ADR_LO = 7'h37;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_sel = 1'b1;
  logic [5:0] inp = 6'h2D;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe, stop_pulse;
  logic [5:0] reg_a, reg_b;
  logic [1:0] mode;
  int n_tests = 0;
  int n_fail = 0;
  int stop_cnt = 0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  cfg_i2c_port #(.COMMIT_CYCLES(COMMIT)) uut (
    .clk(clk), .rst(rst), .addr_sel(addr_sel), .in_port(inp),
    .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_a(reg_a), .reg_b(reg_b), .mode(mode), .stop_pulse(stop_pulse)
  );

  always @(posedge clk) if (!rst && stop_pulse) stop_cnt <= stop_cnt + 1;

  // {write byte, expected A, expected B, expected mode}
  localparam logic [21:0] VEC [5] = '{
    {8'h15, 6'h15, 6'h00, 2'd0},
    {8'h6A, 6'h15, 6'h2A, 2'd1},
    {8'hBF, 6'h3F, 6'h2A, 2'd2},
    {8'hC1, 6'h3F, 6'h01, 2'd3},
    {8'h00, 6'h00, 6'h01, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H); scl = 1'b1; wt(H); scl = 1'b0;
    end
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H/2); ack = ~sda_bus; wt(H/2); scl = 1'b0;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl = 1'b1; wt(H/2); b[i] = sda_bus; wt(H/2); scl = 1'b0;
    end
    sda_m = ~give_ack; wt(H); scl = 1'b1; wt(H); scl = 1'b0; wt(2); sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                          output logic ack_a, output logic ack_d);
    i2c_start; put_byte({a, 1'b0}, ack_a); put_byte(d, ack_d); i2c_stop;
  endtask

  task automatic do_read4(output logic ack_a, output logic [7:0] b0, b1, b2, b3);
    i2c_start; put_byte({ADR_HI, 1'b1}, ack_a);
    get_byte(1'b1, b0); get_byte(1'b1, b1); get_byte(1'b1, b2);
    inp = inp + 6'h05;
    get_byte(1'b0, b3); i2c_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic aa, ad;
    logic [7:0] b0, b1, b2, b3;
    int sc;
    wt(6); rst = 1'b0; wt(4);
    chk("R10 reset reg_a", reg_a, 0);
    chk("R10 reset reg_b", reg_b, 0);
    chk("R10 reset mode", mode, 0);
    chk("R10 reset sda_oe", sda_oe, 0);

    // Vector walk: write, commit, read back full stream
    for (int v = 0; v < 5; v++) begin
      logic [7:0] wb; logic [5:0] ea, eb; logic [1:0] em;
      logic [5:0] a0, bb0; logic [1:0] m0;
      {wb, ea, eb, em} = VEC[v];
      a0 = reg_a; bb0 = reg_b; m0 = mode;
      sc = stop_cnt;
      do_write(ADR_HI, wb, aa, ad);
      chk("R2 address ack", aa, 1);
      chk("R4 data ack", ad, 1);
      chk("R5 not early", {reg_a, reg_b, mode}, {a0, bb0, m0});
      chk("R1 one stop pulse", stop_cnt - sc, 1);
      wt(COMMIT + 100);
      chk("R4 reg_a", reg_a, ea);
      chk("R4 reg_b", reg_b, eb);
      chk("R4 shared mode", mode, em);
      do_read4(aa, b0, b1, b2, b3);
      chk("R6 byte0 A", b0, {2'b00, ea});
      chk("R6 byte1 B", b1, {2'b00, eb});
      chk("R6 byte2 port", b2, {2'b00, inp - 6'h05});
      chk("R6 byte3 port repeat", b3, {2'b00, inp});
      chk("R8 read keeps regs", {reg_a, reg_b, mode}, {ea, eb, em});
      inp = inp + 6'h0B;
    end

    // Wrong strap address and general call
    do_write(ADR_LO, 8'h7F, aa, ad);
    chk("R3 wrong addr nack", aa, 0);
    chk("R3 ignored data nack", ad, 0);
    do_write(7'h00, 8'h3F, aa, ad);
    chk("R3 general call nack", aa, 0);
    wt(COMMIT + 100);
    chk("R3 regs untouched", {reg_a, reg_b, mode}, {6'h00, 6'h01, 2'd0});

    // Strap low selects the other address
    addr_sel = 1'b0;
    do_write(ADR_HI, 8'h55, aa, ad);
    chk("R2 strap0 rejects high addr", aa, 0);
    do_write(ADR_LO, 8'h47, aa, ad);
    chk("R2 strap0 low addr ack", aa, 1);
    wt(COMMIT + 100);
    chk("R2 strap0 write B", {reg_b, mode}, {6'h07, 2'd1});
    addr_sel = 1'b1;

    // Replacement of a pending commit
    do_write(ADR_HI, 8'h05, aa, ad);
    do_write(ADR_HI, 8'h09, aa, ad);
    wt(1500);
    chk("R5 first write replaced", reg_a, 6'h00);
    wt(COMMIT);
    chk("R5 second write lands", {reg_a, mode}, {6'h09, 2'd0});

    // Read only A, NACK, then repeated start into a write
    i2c_start; put_byte({ADR_HI, 1'b1}, aa);
    get_byte(1'b0, b0);
    wt(4);
    chk("R7 sda released after nack", sda_oe, 0);
    chk("R7 single byte is A", b0, {2'b00, 6'h09});
    i2c_start;
    put_byte({ADR_HI, 1'b0}, aa);
    chk("R9 repeated start addr ack", aa, 1);
    put_byte(8'h62, ad);
    i2c_stop;
    wt(COMMIT + 100);
    chk("R9 write after repeated start", {reg_b, mode}, {6'h22, 2'd1});

    // Repeated start straight after a write address
    i2c_start; put_byte({ADR_HI, 1'b0}, aa);
    i2c_start; put_byte({ADR_HI, 1'b1}, aa);
    chk("R9 restart into read ack", aa, 1);
    get_byte(1'b0, b0); i2c_stop;
    chk("R9 restart read A", b0, {2'b00, 6'h09});
    wt(10);
    chk("R7 idle after read", sda_oe, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule